// File: doc/BRIEF.md
# Bit Manipulation Execution Slice

This slice executes one of four bit-manipulation operations per issued instruction, chosen by a 2-bit operation code. Operation 00 is the only one that takes two sources. It merges the low 16 bits of the first source with a 16-bit second source into a 32-bit word whose bits alternate between the two. A typical use is turning a pair of (x, y) texel coordinates into a Morton-ordered offset for a tiled surface. The other three codes act only on the 32-bit first source: 01 mirrors its bit order, 10 counts its ones, and 11 reports the position of its lowest one.

The result is held in a register. An operation issued with `inValid` high in one cycle produces its result on `outResult`, with `outValid` high, in the next cycle. When nothing is issued, the previous result stays on the output.

Top module: `bitmanip_unit`

## Requirements
- R1: After reset, `outValid` is 0 and `outResult` is 0.
- R2: `outValid` is high in exactly those cycles that follow a cycle with `inValid` high. The result of that operation is on `outResult` in the same cycle.
- R3: While `inValid` is low, `outResult` keeps its last value whatever the other inputs do.
- R4: With `inOp` = 2'b00 (interleave), result bit 2i equals `srcA[i]` and result bit 2i+1 equals `srcB[i]`, for i from 0 to 15.
- R5: The interleave operation ignores `srcA[31:16]`.
- R6: With `inOp` = 2'b01 (reverse), result bit i equals `srcA[31-i]`.
- R7: With `inOp` = 2'b10 (population count), the result is the number of ones in `srcA`, zero-extended to 32 bits, so its range is 0 to 32.
- R8: With `inOp` = 2'b11 (find first set), the result is the index of the least significant one in `srcA`, in the range 0 to 31.
- R9: Find first set on `srcA` = 0 returns 32'hFFFFFFFF.
- R10: Operation codes 01, 10 and 11 ignore `srcB`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issues an operation this cycle |
| inOp | input | 2 | Operation code: 00 interleave, 01 reverse, 10 popcount, 11 find first set |
| srcA | input | 32 | First source. Only bits 15:0 are used for interleave |
| srcB | input | 16 | Second source, used only by interleave |
| outValid | output | 1 | Result register holds a freshly issued result |
| outResult | output | 32 | Registered result |

## Verification
The properties assume that reset is asserted at the start and that `inOp`, `srcA` and `srcB` are valid and stable around each clock edge on which `inValid` is high. The bench meets this by changing inputs only on the falling clock edge. Each result property looks one cycle back, guarded by `outValid`, so it only judges operands that were actually issued. The bench keeps several operations back to back and also leaves idle gaps, and it drives arbitrary operands during idle cycles to exercise the hold behaviour.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  typedef enum logic [1:0] {
    OP_WEAVE = 2'b00,
    OP_REV   = 2'b01,
    OP_POP   = 2'b10,
    OP_FFS   = 2'b11
  } bmuOp_e;

  typedef struct packed {
    logic   loadEn;
    bmuOp_e opSel;
  } bmuStrobe_t;
endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inOp,
  output bmuStrobe_t strobe,
  output logic       outValid
);
  always_comb begin
    strobe.loadEn = inValid;
    strobe.opSel  = bmuOp_e'(inOp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  bmuStrobe_t          strobe,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W/2-1:0] srcB,
  output logic [DATA_W-1:0]   outResult
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int IDX_W  = $clog2(DATA_W);

  logic [DATA_W-1:0] weaveRes, revRes, popRes, ffsRes, nextRes;
  logic [CNT_W-1:0]  popCnt;
  logic [IDX_W-1:0]  ffsIdx;
  logic              anySet;

  for (genvar i = 0; i < HALF_W; i++) begin : g_weave
    assign weaveRes[2*i]   = srcA[i];
    assign weaveRes[2*i+1] = srcB[i];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign revRes[i] = srcA[DATA_W-1-i];
  end

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < DATA_W; i++) popCnt = popCnt + CNT_W'(srcA[i]);
    popRes = {{(DATA_W-CNT_W){1'b0}}, popCnt};
  end

  always_comb begin
    ffsIdx = '0;
    anySet = 1'b0;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      if (srcA[i]) begin
        ffsIdx = IDX_W'(i);
        anySet = 1'b1;
      end
    end
    ffsRes = anySet ? {{(DATA_W-IDX_W){1'b0}}, ffsIdx} : {DATA_W{1'b1}};
  end

  always_comb begin
    unique case (strobe.opSel)
      OP_WEAVE: nextRes = weaveRes;
      OP_REV:   nextRes = revRes;
      OP_POP:   nextRes = popRes;
      OP_FFS:   nextRes = ffsRes;
      default:  nextRes = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              outResult <= '0;
    else if (strobe.loadEn) outResult <= nextRes;
  end
endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
  import bmu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          inOp,
  input  logic [DATA_W-1:0]   srcA,
  input  logic [DATA_W/2-1:0] srcB,
  output logic                outValid,
  output logic [DATA_W-1:0]   outResult
);
  bmuStrobe_t strobe;

  bmu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
    .strobe(strobe), .outValid(outValid)
  );

  bmu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .outResult(outResult)
  );
endmodule

// File: rtl/bmu_checker.sv
module bmu_checker #(
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [1:0]          inOp,
  input logic [DATA_W-1:0]   srcA,
  input logic [DATA_W/2-1:0] srcB,
  input logic                outValid,
  input logic [DATA_W-1:0]   outResult
);
  localparam int HALF_W = DATA_W / 2;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outResult));
  a_r4_weave_ones: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 2'b00 |=>
      $countones(outResult) == $countones($past(srcA[HALF_W-1:0])) + $countones($past(srcB)));
  a_r6_rev_ones: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 2'b01 |=> $countones(outResult) == $countones($past(srcA)));
  a_r7_pop_range: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 2'b10 |=> outResult <= DATA_W);
  a_r8_ffs_range: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 2'b11 && srcA != '0 |=> outResult < DATA_W);
  a_r9_ffs_zero: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 2'b11 && srcA == '0 |=> outResult == {DATA_W{1'b1}});
endmodule

bind bitmanip_unit bmu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp),
  .srcA(srcA), .srcB(srcB), .outValid(outValid), .outResult(outResult)
);

// File: tb/sim_bitmanip_unit.sv
module sim_bitmanip_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  inOp = 2'b00;
  logic [31:0] srcA = '0;
  logic [15:0] srcB = '0;
  logic        outValid;
  logic [31:0] outResult;
  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  bitmanip_unit u0 (.*);

  localparam int NV = 15;
  // {op, srcA, srcB, expected}
  localparam logic [81:0] VEC [NV] = '{
    {2'b00, 32'h0000FFFF, 16'h0000, 32'h55555555},
    {2'b00, 32'h00000000, 16'hFFFF, 32'hAAAAAAAA},
    {2'b00, 32'hFFFF0000, 16'h0000, 32'h00000000},
    {2'b00, 32'h000000FF, 16'h00FF, 32'h0000FFFF},
    {2'b00, 32'h00005555, 16'h0000, 32'h11111111},
    {2'b00, 32'h00000000, 16'hAAAA, 32'h88888888},
    {2'b01, 32'h00000001, 16'hFFFF, 32'h80000000},
    {2'b01, 32'hF0000000, 16'h1234, 32'h0000000F},
    {2'b10, 32'hFFFFFFFF, 16'h0000, 32'h00000020},
    {2'b10, 32'h00000000, 16'hFFFF, 32'h00000000},
    {2'b10, 32'h80000001, 16'hFFFF, 32'h00000002},
    {2'b11, 32'h00000000, 16'hFFFF, 32'hFFFFFFFF},
    {2'b11, 32'h80000000, 16'h0001, 32'h0000001F},
    {2'b11, 32'h00000100, 16'h0000, 32'h00000008},
    {2'b11, 32'hFFFFFFFF, 16'hFFFF, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one op; returns after result is visible (one cycle later, at negedge)
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [15:0] b);
    @(negedge clk);
    inValid = 1'b1; inOp = op; srcA = a; srcB = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  function automatic logic [31:0] refWeave(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      r[2*i] = a[i];
      r[2*i+1] = b[i];
    end
    return r;
  endfunction

  function automatic logic [31:0] refPop(input logic [31:0] a);
    logic [31:0] n = '0;
    for (int i = 0; i < 32; i++) if (a[i]) n++;
    return n;
  endfunction

  function automatic logic [31:0] refFfs(input logic [31:0] a);
    for (int i = 0; i < 32; i++) if (a[i]) return 32'(i);
    return 32'hFFFFFFFF;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    string tag;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 outValid", {31'b0, outValid}, 32'h0);
    check("R1 outResult", outResult, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'b0, outValid}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k][81:80], VEC[k][79:48], VEC[k][47:32]);
      case (VEC[k][81:80])
        2'b00: tag = "R4/R5 weave";
        2'b01: tag = "R6/R10 reverse";
        2'b10: tag = "R7/R10 popcount";
        default: tag = "R8/R9/R10 ffs";
      endcase
      check("R2 valid", {31'b0, outValid}, 32'h1);
      check(tag, outResult, VEC[k][31:0]);
    end

    // R3: idle cycles with changing inputs must not alter result
    held = outResult;
    @(negedge clk);
    check("R2 valid drops", {31'b0, outValid}, 32'h0);
    for (int k = 0; k < 4; k++) begin
      inOp = 2'(k); srcA = $urandom; srcB = 16'($urandom);
      @(negedge clk);
      check("R3 hold", outResult, held);
      check("R3 no valid", {31'b0, outValid}, 32'h0);
    end

    // R4/R5 random interleave, upper srcA bits random
    for (int k = 0; k < 200; k++) begin
      logic [31:0] a = $urandom;
      logic [15:0] b = 16'($urandom);
      issue(2'b00, a, b);
      check("R4 weave random", outResult, refWeave(a[15:0], b));
    end
    // R7 / R8 random
    for (int k = 0; k < 100; k++) begin
      logic [31:0] a = $urandom;
      issue(2'b10, a, 16'($urandom));
      check("R7 popcount random", outResult, refPop(a));
      a = a & ~(32'hFFFFFFFF >> (k % 32)) | (32'h1 << (k % 32));
      issue(2'b11, a, 16'($urandom));
      check("R8 ffs random", outResult, refFfs(a));
    end
    // R10: srcB must not change single-source results
    issue(2'b01, 32'h12345678, 16'h0000);
    held = outResult;
    issue(2'b01, 32'h12345678, 16'hFFFF);
    check("R10 reverse ignores srcB", outResult, held);
    check("R6 reverse value", outResult, 32'h1E6A2C48);

    // R2 back-to-back issue
    @(negedge clk);
    inValid = 1'b1; inOp = 2'b10; srcA = 32'h0000000F; srcB = '0;
    @(negedge clk);
    check("R2 b2b first", outResult, 32'd4);
    inOp = 2'b11; srcA = 32'h00000040;
    @(negedge clk);
    inValid = 1'b0;
    check("R2 b2b second", outResult, 32'd6);
    check("R2 b2b valid", {31'b0, outValid}, 32'h1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule